// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block controls the protection side of a static memory that keeps its contents on a backup cell. External comparators supply three digital levels: the supply is below the fail threshold, the supply is below the switch-over level, and the supply is above the backup cell voltage. The host supplies one more input, a flag that is high while an access cycle is in flight. From these inputs the sequencer drives three outputs. The first is a write-protect/deselect line for the memory array. While it is high, the array floats its data pins and ignores its inputs. The second selects the main supply or the backup cell. The third shows that the backup cell is still isolated.

All delays count cycles of the block's clock, which is a slow timebase. The fail threshold is a build-time choice made in the comparator, so this logic only sees the comparator's decision. When a fail is detected during an access, that access may finish, but only within a bounded window. After power returns, protection stays on for a long guard period so the host can settle. Until main power has been seen once, the backup cell stays disconnected.

Top module: `pwr_guard_seq`

## Requirements
- R1: After reset, `wr_protect` is 1, `use_backup` is 0 and `cell_isolated` is 1.
- R2: While `cell_isolated` is 1, `use_backup` stays 0 even when both supply-low inputs are high. `cell_isolated` clears on the first clock edge that samples `below_fail` low. After that it never returns to 1 until the next reset.
- R3: When `wr_protect` is 0 and an edge samples `below_fail` high with `access_busy` low, `wr_protect` is 1 after that edge.
- R4: When an edge samples `below_fail` high with `access_busy` high while unprotected, `wr_protect` stays 0. It rises after the first later edge that samples `access_busy` low, or at the latest exactly WPT_CYCLES edges after the first one, whichever comes first.
- R5: Once a fail has started the pending window, a return of the supply does not cancel it. Protection is still applied when the window ends.
- R6: When the cell is no longer isolated and an edge samples `below_fail` and `below_swo` both high, `use_backup` is 1 after that edge.
- R7: `use_backup` returns to 0 on an edge that samples `above_cell` high with `below_swo` low. Otherwise it holds its value.
- R8: Once protected, `wr_protect` falls exactly REC_CYCLES edges after the first edge that samples `below_fail` low. `below_fail` must stay low through that whole period, and `access_busy` has no effect on it.
- R9: If `below_fail` is sampled high during the recovery period, `wr_protect` stays 1. The recovery count then restarts from zero when the supply next returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_fail | input | 1 | Supply is below the fail threshold |
| below_swo | input | 1 | Supply is below the switch-over level |
| above_cell | input | 1 | Supply is above the backup cell voltage |
| access_busy | input | 1 | A host access cycle is in flight |
| wr_protect | output | 1 | Write-protect / deselect for the array |
| use_backup | output | 1 | 1 selects the backup cell, 0 the main supply |
| cell_isolated | output | 1 | Backup cell still disconnected |

## Verification
Some properties are checked by the assertions on every cycle:
- backup is never selected while the cell is isolated, and isolation never comes back once cleared;
- a fail with no access in flight protects at once;
- protection cannot be withheld longer than the pending window;
- protection never drops unless the supply was good on that edge;
- a fail during recovery keeps protection on.

Other behaviour only the bench's scenarios can show:
- the exact length of the pending window and of the recovery period;
- the early release of protection when the access flag drops;
- the restart of the recovery count after a fail during recovery;
- the order in which the supply select switches.

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq #(
  parameter int WPT_CYCLES = 10,
  parameter int REC_CYCLES = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_fail,
  input  logic below_swo,
  input  logic above_cell,
  input  logic access_busy,
  output logic wr_protect,
  output logic use_backup,
  output logic cell_isolated
);

  localparam int MAXC = (WPT_CYCLES > REC_CYCLES) ? WPT_CYCLES : REC_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int KW   = $clog2(WPT_CYCLES + 3);

  typedef enum logic [2:0] {S_ISO, S_RUN, S_PEND, S_HOLD, S_REC} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = '0;
    case (st)
      S_ISO:  if (!below_fail) st_n = S_REC;
      S_RUN:  if (below_fail) st_n = access_busy ? S_PEND : S_HOLD;
      S_PEND: begin
        if (!access_busy || cnt == CW'(WPT_CYCLES - 1)) st_n = S_HOLD;
        else cnt_n = cnt + 1'b1;
      end
      S_HOLD: if (!below_fail) st_n = S_REC;
      S_REC: begin
        if (below_fail) st_n = S_HOLD;
        else if (cnt == CW'(REC_CYCLES - 1)) st_n = S_RUN;
        else cnt_n = cnt + 1'b1;
      end
      default: st_n = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_ISO;
      cnt           <= '0;
      cell_isolated <= 1'b1;
      use_backup    <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      if (st == S_ISO && !below_fail) cell_isolated <= 1'b0;
      if (!cell_isolated) begin
        if (below_fail && below_swo) use_backup <= 1'b1;
        else if (above_cell && !below_swo) use_backup <= 1'b0;
      end
    end
  end

  assign wr_protect = (st != S_RUN) && (st != S_PEND);

  logic [KW-1:0] unprot_k;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unprot_k <= '0;
    else if (wr_protect) unprot_k <= '0;
    else if (below_fail || unprot_k != '0) unprot_k <= unprot_k + 1'b1;
  end

  AST_ISO_NO_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
    cell_isolated |-> !use_backup); // R2
  AST_ISO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_isolated |=> !cell_isolated); // R2
  AST_FAIL_IDLE_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_protect && below_fail && !access_busy) |=> wr_protect); // R3
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_k <= KW'(WPT_CYCLES + 1)); // R4
  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_protect) |-> !$past(below_fail)); // R8
  AST_REC_REFAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_protect && below_fail) |=> wr_protect); // R9

endmodule

// File: tb/tb_pwr_guard_seq.sv
module tb_pwr_guard_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WPT = 4;
  localparam int REC = 6;
  localparam int NV  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic below_fail = 1'b1, below_swo = 1'b1, above_cell = 1'b0, access_busy = 1'b0;
  logic wr_protect, use_backup, cell_isolated;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_guard_seq #(.WPT_CYCLES(WPT), .REC_CYCLES(REC)) dut (
    .clk(clk), .rst_n(rst_n), .below_fail(below_fail), .below_swo(below_swo),
    .above_cell(above_cell), .access_busy(access_busy), .wr_protect(wr_protect),
    .use_backup(use_backup), .cell_isolated(cell_isolated));

  // {below_fail, below_swo, above_cell, access_busy}, edges, {wr_protect, use_backup, cell_isolated}
  localparam logic [14:0] VEC [NV] = '{
    {4'b1100, 8'd3, 3'b101}, {4'b0010, 8'd1, 3'b100}, {4'b0010, 8'd5, 3'b100},
    {4'b0010, 8'd1, 3'b000}, {4'b1011, 8'd1, 3'b000}, {4'b1011, 8'd3, 3'b000},
    {4'b1011, 8'd1, 3'b100}, {4'b1100, 8'd1, 3'b110}, {4'b0000, 8'd1, 3'b110},
    {4'b0010, 8'd1, 3'b100}, {4'b1000, 8'd1, 3'b100}, {4'b0010, 8'd6, 3'b100},
    {4'b0010, 8'd1, 3'b000}, {4'b1001, 8'd1, 3'b000}, {4'b1000, 8'd1, 3'b100},
    {4'b0010, 8'd7, 3'b000}, {4'b1010, 8'd1, 3'b100}, {4'b0010, 8'd7, 3'b000},
    {4'b1011, 8'd1, 3'b000}, {4'b0011, 8'd3, 3'b000}, {4'b0011, 8'd1, 3'b100},
    {4'b0011, 8'd1, 3'b100}, {4'b0011, 8'd5, 3'b100}, {4'b0011, 8'd1, 3'b000}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:          return "R2";
      2, 3:          return "R8";
      4, 5, 6:       return "R4";
      7:             return "R6";
      8, 9:          return "R7";
      10, 11, 12:    return "R9";
      13, 14:        return "R4";
      15, 17:        return "R8";
      16:            return "R3";
      18, 19, 20:    return "R5";
      default:       return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {wr_protect, use_backup, cell_isolated};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {wp,bk,iso} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", 3'b101);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {below_fail, below_swo, above_cell, access_busy} = VEC[i][14:11];
      for (int k = 0; k < int'(VEC[i][10:3]); k++) @(posedge clk);
      @(negedge clk);
      check(req_of(i), VEC[i][2:0]);
    end
    // R1 again: mid-run reset restores isolation and protection
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 3'b101);
    // R2: isolated cell ignores a deep supply drop
    {below_fail, below_swo, above_cell, access_busy} = 4'b1100;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", 3'b101);
    finish_run();
  end
endmodule